// File: doc/BRIEF.md
# Converter Calibration Sequencer

This block decides when a data converter runs its self-calibration and raises a running flag for the whole calibration interval. After reset it waits out a power-on settling delay, whose length is picked by a delay-select pin, and then runs a first calibration on its own. After that, a calibration starts for one of two reasons. The first is a manual request that passes noise qualification: it must be low for a minimum number of cycles and then high for a minimum number of cycles. The second is any change of level on the delay-select pin.

The manual request normally comes from a pin. In extended control mode it is the OR of that pin and a register bit, so both must return low before a new request can qualify. Every calibration, whatever started it, lasts the same fixed number of cycles. Requests and delay-select changes that arrive while a calibration runs, or during the power-on wait, are dropped. Qualification begins again from nothing once the running flag falls.

Top module: `cal_seq`

## Requirements
- R1: While rst_n is low, cal_run_o is 0. After rst_n is released the block is in its power-on wait, and a manual request or a delay-select change during that wait does not start a calibration.
- R2: With dly_sel_i low, cal_run_o first rises at the POR_SHORT-th rising clock edge after rst_n is released.
- R3: With dly_sel_i high, cal_run_o first rises at the POR_LONG-th rising clock edge after rst_n is released.
- R4: Suppose the request is sampled low on T_LO consecutive edges and then sampled high on T_HI consecutive edges. Then cal_run_o rises on the edge that follows the T_HI-th high edge.
- R5: A high phase shorter than T_HI edges starts nothing. The low phase must then be qualified again.
- R6: A low phase shorter than T_LO edges that comes after a high phase does not arm the qualifier, so a following full-length high phase starts nothing.
- R7: Each calibration holds cal_run_o high for exactly T_CAL consecutive cycles, whatever its source.
- R8: With ext_mode_i = 1, the request is cal_pin_i OR cal_bit_i. A qualified pulse on cal_bit_i alone starts a calibration.
- R9: With ext_mode_i = 0, cal_bit_i has no effect.
- R10: With ext_mode_i = 1, a high cal_pin_i keeps the request high, so pulses on cal_bit_i cannot re-arm the qualifier.
- R11: While idle, a level change on dly_sel_i makes cal_run_o rise on the third rising edge after the change: two synchronizer stages plus one register.
- R12: A request completed, or a dly_sel_i change made, while cal_run_o is high is ignored. A request held high across the end of a calibration does not start another one.
- R13: A qualified manual request and a delay-select change that reach the controller in the same cycle produce a single calibration of T_CAL cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, deasserted synchronously to clk |
| cal_pin_i | input | 1 | Manual calibration request pin |
| cal_bit_i | input | 1 | Manual calibration request register bit (used in extended mode) |
| ext_mode_i | input | 1 | 1 selects extended control, where pin and bit are ORed |
| dly_sel_i | input | 1 | Power-on delay select, asynchronous; a change starts a calibration |
| cal_run_o | output | 1 | High while a calibration is running |

## Verification
Two start sources can meet in the same controller cycle: the registered pulse of the manual qualifier and the edge pulse from the synchronized delay-select pin. The bench provokes this by flipping dly_sel_i exactly T_HI-2 edges after raising the request, so that both pulses arrive at the third edge after the flip. It then requires one rise of cal_run_o at the latency the manual path predicts, one high interval of exactly T_CAL cycles, and no second calibration afterwards.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;
  typedef enum logic [1:0] {
    ST_POR  = 2'd0,
    ST_IDLE = 2'd1,
    ST_RUN  = 2'd2
  } cal_state_e;
endpackage

// File: rtl/cal_qual.sv
// Low-then-high pulse-width qualifier for the manual calibration request.
module cal_qual #(
  parameter int T_LO = 4,
  parameter int T_HI = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic hold_i,
  output logic start_o
);
  localparam int LW = $clog2(T_LO + 1);
  localparam int HW = $clog2(T_HI + 1);
  localparam logic [LW-1:0] LO_LAST = LW'(T_LO - 1);
  localparam logic [LW-1:0] LO_SAT  = LW'(T_LO);
  localparam logic [HW-1:0] HI_LAST = HW'(T_HI - 1);

  logic [LW-1:0] lo_cnt_q, lo_cnt_d;
  logic [HW-1:0] hi_cnt_q, hi_cnt_d;
  logic          armed_q, armed_d;
  logic          req_q;
  logic          start_q, start_d;

  always_comb begin
    lo_cnt_d = lo_cnt_q;
    hi_cnt_d = hi_cnt_q;
    armed_d  = armed_q;
    start_d  = 1'b0;
    if (hold_i) begin
      lo_cnt_d = '0;
      hi_cnt_d = '0;
      armed_d  = 1'b0;
    end else if (!req_i) begin
      hi_cnt_d = '0;
      lo_cnt_d = (lo_cnt_q == LO_SAT) ? lo_cnt_q : lo_cnt_q + 1'b1;
      // a high phase that ended without firing drops the arming
      armed_d  = (armed_q && !req_q) || (lo_cnt_q == LO_LAST);
    end else begin
      lo_cnt_d = '0;
      if (armed_q) begin
        if (hi_cnt_q == HI_LAST) begin
          start_d  = 1'b1;
          armed_d  = 1'b0;
          hi_cnt_d = '0;
        end else begin
          hi_cnt_d = hi_cnt_q + 1'b1;
        end
      end else begin
        hi_cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt_q <= '0;
      hi_cnt_q <= '0;
      armed_q  <= 1'b0;
      req_q    <= 1'b0;
      start_q  <= 1'b0;
    end else begin
      lo_cnt_q <= lo_cnt_d;
      hi_cnt_q <= hi_cnt_d;
      armed_q  <= armed_d;
      req_q    <= req_i;
      start_q  <= start_d;
    end
  end

  assign start_o = start_q;
endmodule

// File: rtl/cal_dly_watch.sv
// Synchronizes the delay-select pin and flags a change of its level.
module cal_dly_watch #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dly_i,
  output logic level_o,
  output logic toggle_o
);
  logic [STAGES:0] shf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shf_q <= '0;
    else        shf_q <= {shf_q[STAGES-1:0], dly_i};
  end

  assign level_o  = shf_q[STAGES-1];
  assign toggle_o = shf_q[STAGES] ^ shf_q[STAGES-1];
endmodule

// File: rtl/cal_ctrl.sv
// Power-on wait, idle and run states with one shared cycle counter.
module cal_ctrl
  import cal_seq_pkg::*;
#(
  parameter int T_CAL     = 10,
  parameter int POR_SHORT = 20,
  parameter int POR_LONG  = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic long_sel_i,
  input  logic start_i,
  input  logic toggle_i,
  output logic busy_o,
  output logic idle_o,
  output logic por_wait_o
);
  localparam int MAXA = (POR_LONG > POR_SHORT) ? POR_LONG : POR_SHORT;
  localparam int MAXC = (MAXA > T_CAL) ? MAXA : T_CAL;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SHORT_LAST = CW'(POR_SHORT - 1);
  localparam logic [CW-1:0] LONG_LAST  = CW'(POR_LONG - 1);
  localparam logic [CW-1:0] RUN_LAST   = CW'(T_CAL - 1);

  cal_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] por_last;

  assign por_last = long_sel_i ? LONG_LAST : SHORT_LAST;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_POR: begin
        if (cnt_q >= por_last) begin
          st_d  = ST_RUN;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_IDLE: begin
        if (start_i || toggle_i) begin
          st_d  = ST_RUN;
          cnt_d = '0;
        end
      end
      ST_RUN: begin
        if (cnt_q == RUN_LAST) begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        st_d  = ST_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_POR;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign busy_o     = (st_q == ST_RUN);
  assign idle_o     = (st_q == ST_IDLE);
  assign por_wait_o = (st_q == ST_POR);
endmodule

// File: rtl/cal_seq.sv
module cal_seq #(
  parameter int T_LO      = 4,
  parameter int T_HI      = 3,
  parameter int T_CAL     = 10,
  parameter int POR_SHORT = 20,
  parameter int POR_LONG  = 40,
  parameter int SYNC      = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cal_pin_i,
  input  logic cal_bit_i,
  input  logic ext_mode_i,
  input  logic dly_sel_i,
  output logic cal_run_o
);
  logic req_w;
  logic qual_start;
  logic dly_level;
  logic dly_toggle;
  logic busy;
  logic idle;
  logic por_wait;

  assign req_w = cal_pin_i | (ext_mode_i & cal_bit_i);

  cal_qual #(.T_LO(T_LO), .T_HI(T_HI)) u_qual (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req_w),
    .hold_i  (!idle),
    .start_o (qual_start)
  );

  cal_dly_watch #(.STAGES(SYNC)) u_dly (
    .clk      (clk),
    .rst_n    (rst_n),
    .dly_i    (dly_sel_i),
    .level_o  (dly_level),
    .toggle_o (dly_toggle)
  );

  cal_ctrl #(.T_CAL(T_CAL), .POR_SHORT(POR_SHORT), .POR_LONG(POR_LONG)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .long_sel_i (dly_level),
    .start_i    (qual_start),
    .toggle_i   (dly_toggle),
    .busy_o     (busy),
    .idle_o     (idle),
    .por_wait_o (por_wait)
  );

  assign cal_run_o = busy;
endmodule

// File: rtl/cal_seq_chk.sv
module cal_seq_chk #(
  parameter int T_CAL = 10
) (
  input logic clk,
  input logic rst_n,
  input logic cal_run,
  input logic req,
  input logic qual_start,
  input logic dly_toggle,
  input logic por_wait
);
  localparam int LW = $clog2(T_CAL + 2);
  logic [LW-1:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       len_q <= '0;
    else if (cal_run) len_q <= len_q + 1'b1;
    else              len_q <= '0;
  end

  always @(negedge clk) begin
    if (!rst_n) assert_reset_quiet_R1: assert (!cal_run);
  end

  assert_run_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cal_run) |-> (len_q == LW'(T_CAL)));

  assert_run_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_run) |-> ($past(qual_start) || $past(dly_toggle) || $past(por_wait)));

  assert_start_on_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    qual_start |-> $past(req));

  assert_no_start_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_run && $past(cal_run)) |-> !qual_start);
endmodule

bind cal_seq cal_seq_chk #(.T_CAL(T_CAL)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cal_run    (cal_run_o),
  .req        (req_w),
  .qual_start (qual_start),
  .dly_toggle (dly_toggle),
  .por_wait   (por_wait)
);

// File: tb/cal_seq_tb.sv
`timescale 1ns/1ps
module cal_seq_tb;
  localparam int T_LO = 4, T_HI = 3, T_CAL = 10, POR_S = 20, POR_L = 40;

  logic clk = 1'b0;
  logic rst_n, pin, cbit, ext, dsel;
  logic run;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  cal_seq #(.T_LO(T_LO), .T_HI(T_HI), .T_CAL(T_CAL),
            .POR_SHORT(POR_S), .POR_LONG(POR_L)) u_dut (
    .clk(clk), .rst_n(rst_n), .cal_pin_i(pin), .cal_bit_i(cbit),
    .ext_mode_i(ext), .dly_sel_i(dsel), .cal_run_o(run));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // watch the run flag for n cycles: first rise index, rises, high cycles
  task automatic watch(input int n, output int rise, output int nr, output int width);
    logic prev = run;
    rise = 0; nr = 0; width = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (run && !prev) begin nr++; if (rise == 0) rise = i; end
      if (run) width++;
      prev = run;
    end
  endtask

  task automatic t_reset(input logic sel, input string tag, input int exp);
    int lat = 0, w = 0;
    rst_n = 1'b0; pin = 0; cbit = 0; ext = 0; dsel = sel;
    repeat (3) @(negedge clk);
    chk(run == 1'b0, "R1", run, 0);
    rst_n = 1'b1;
    while (!run && lat < 200) begin @(negedge clk); lat++; end
    chk(lat == exp, tag, lat, exp);
    while (run && w < 200) begin @(negedge clk); w++; end
    chk(w == T_CAL, "R7", w, T_CAL);
  endtask

  // src 0 drives the pin, 1 the bit; exp_lat 0 means no calibration expected
  task automatic t_pulse(input int src, input int lo, input int hi,
                         input int exp_lat, input string tag);
    int rise, nr, w;
    if (src == 0) pin = 1; else cbit = 1;
    @(negedge clk);
    if (src == 0) pin = 0; else cbit = 0;
    repeat (lo) @(negedge clk);
    if (src == 0) pin = 1; else cbit = 1;
    repeat (hi) @(negedge clk);
    if (src == 0) pin = 0; else cbit = 0;
    watch(40, rise, nr, w);
    if (rise != 0) rise += hi;
    chk(rise == exp_lat, tag, rise, exp_lat);
    if (exp_lat != 0) chk(w == T_CAL && nr == 1, "R7", w, T_CAL);
  endtask

  task automatic t_toggle();
    int rise, nr, w;
    dsel = ~dsel;
    watch(30, rise, nr, w);
    chk(rise == 3, "R11", rise, 3);
  endtask

  task automatic t_busy_ignore();
    int rise, nr, w;
    pin = 0;
    repeat (T_LO) @(negedge clk);
    pin = 1;
    while (!run) @(negedge clk);
    dsel = ~dsel;
    repeat (2) @(negedge clk);
    cbit = 1;
    watch(45, rise, nr, w);
    chk(nr == 0 && w == T_CAL - 3, "R12", w, T_CAL - 3);
    pin = 0; cbit = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_ext_block();
    int rise, nr, w;
    ext = 1; pin = 0; cbit = 0;
    repeat (T_LO) @(negedge clk);
    pin = 1;
    watch(30, rise, nr, w);
    chk(nr == 1, "R10", nr, 1);
    cbit = 0;
    repeat (T_LO + 2) @(negedge clk);
    cbit = 1;
    watch(30, rise, nr, w);
    chk(nr == 0, "R10", nr, 0);
    pin = 0; cbit = 0; ext = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_collide();
    int rise = 0, nr = 0, w = 0;
    logic prev;
    pin = 0;
    repeat (T_LO) @(negedge clk);
    pin = 1;
    prev = run;
    for (int i = 1; i <= 40; i++) begin
      if (i == T_HI - 1) dsel = ~dsel;
      if (i == T_HI + 1) pin = 0;
      @(negedge clk);
      if (run && !prev) begin nr++; if (rise == 0) rise = i; end
      if (run) w++;
      prev = run;
    end
    chk(rise == T_HI + 1, "R13", rise, T_HI + 1);
    chk(nr == 1 && w == T_CAL, "R13", w, T_CAL);
  endtask

  task automatic t_por_ignore();
    int rise, nr, w;
    rst_n = 1'b0; pin = 0; cbit = 0; ext = 0; dsel = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (T_LO) @(negedge clk);
    pin = 1;
    repeat (T_HI + 1) @(negedge clk);
    pin = 0;
    dsel = 1;
    watch(8, rise, nr, w);
    chk(nr == 0, "R1", nr, 0);
    while (run !== 1'b1) @(negedge clk);
    while (run) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; pin = 0; cbit = 0; ext = 0; dsel = 0;
    @(negedge clk);
    t_reset(1'b0, "R2", POR_S);
    t_pulse(0, T_LO, T_HI, T_HI + 1, "R4");
    t_pulse(0, T_LO, T_HI - 1, 0, "R5");
    t_pulse(0, T_LO - 1, T_HI, 0, "R6");
    t_pulse(1, T_LO, T_HI, 0, "R9");
    ext = 1;
    t_pulse(1, T_LO, T_HI, T_HI + 1, "R8");
    ext = 0;
    t_ext_block();
    t_toggle();
    t_busy_ignore();
    t_collide();
    t_reset(1'b1, "R3", POR_L);
    t_pulse(0, T_LO, T_HI, T_HI + 1, "R4");
    t_por_ignore();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule